// File: doc/BRIEF.md
# Parking Space Availability Controller

This block keeps the number of free spaces in a car park. Three single-cycle pulse inputs drive it: a car leaving (exit sensor), a car arriving (entry sensor) and a driver pressing the ticket button. A small state machine serves one event at a time. A count change passes through a fixed-length add or subtract phase and then a fixed-length display-refresh phase. A ticket request passes through a fixed-length read phase that ends in either a grant or a lot-full answer. The length of every phase is set in clock cycles by a parameter.

Events that arrive while the machine is busy are not lost. Each source has one pending flag. When the machine is idle it serves the flags one per idle cycle, in a fixed priority order. The count is bounded by zero and by the lot capacity. An operation that would cross a bound leaves the count unchanged and raises an error pulse.

Top module: `lot_space_ctrl`

## Requirements
- R1: After reset the free-space count equals the CAPACITY parameter, and `grant`, `lot_full`, `disp_stb` and `sat_err` are low.
- R2: An exit pulse sampled at clock edge E adds one to the count. `disp_stb` is high for the cycle that follows edge E+INC_CYC+UPD_CYC.
- R3: An entry pulse sampled at edge E subtracts one from the count. `disp_stb` is high for the cycle that follows edge E+DEC_CYC+UPD_CYC.
- R4: A ticket pulse sampled at edge E yields exactly one answer pulse, in the cycle that follows edge E+RD_CYC. The answer is `grant` when the count is above zero and `lot_full` when the count is zero. The count does not change.
- R5: An entry at count zero, or an exit at count CAPACITY, leaves the count unchanged. `sat_err` is high for one cycle at the last cycle of the add or subtract phase. The display refresh still follows.
- R6: `disp_stb` lasts one cycle. In that cycle `disp_count` equals the new count.
- R7: Each source latches at most one pending event. Repeated pulses from one source while its flag is already set merge into a single event. A pulse that arrives in the same cycle its flag is taken is kept as a new event.
- R8: Pending events are served one per idle cycle, in priority order exit, entry, ticket. Each service starts the cycle after the previous operation returns to idle.

Top module parameters: CAPACITY (default 500), CNT_W (default 10), INC_CYC, DEC_CYC, RD_CYC and UPD_CYC (defaults 5, 5, 2 and 10, which correspond to 42 ns, 42 ns, 18 ns and 100 ns at a 10 ns clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| car_exit | input | 1 | One-cycle pulse: a car has left |
| car_entry | input | 1 | One-cycle pulse: a car has arrived |
| ticket_req | input | 1 | One-cycle pulse: ticket button pressed |
| grant | output | 1 | One-cycle pulse: ticket request accepted |
| lot_full | output | 1 | One-cycle pulse: ticket request refused, no space |
| disp_stb | output | 1 | One-cycle display refresh strobe |
| disp_count | output | CNT_W | Current free-space count |
| sat_err | output | 1 | One-cycle pulse: operation blocked at a bound |

## Verification
Two functions can meet in one cycle. The first is the idle-state take of a pending flag; the second is a fresh pulse from the same source. The bench provokes this by holding the entry input high for two consecutive edges, and it expects two separate decrements, each followed by its own refresh. It also applies pulses from all three sources and a repeated entry pulse while a decrement is in progress. It judges the result by the order of the refresh values, the exact cycle of each refresh and answer, and the single extra decrement.

// File: rtl/lot_pkg.sv
package lot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INC,
    ST_DEC,
    ST_READ,
    ST_UPD
  } lot_st_e;

  localparam int SRC_N      = 3;
  localparam int SRC_EXIT   = 0;
  localparam int SRC_ENTRY  = 1;
  localparam int SRC_TICKET = 2;

  // True when a step in the given direction would leave [0, cap].
  function automatic logic step_blocked(input int unsigned cnt,
                                        input int unsigned cap,
                                        input logic up);
    return up ? (cnt >= cap) : (cnt == 0);
  endfunction

  // Count after one bounded step.
  function automatic int unsigned step_count(input int unsigned cnt,
                                             input int unsigned cap,
                                             input logic up);
    if (step_blocked(cnt, cap, up)) return cnt;
    return up ? cnt + 1 : cnt - 1;
  endfunction

endpackage

// File: rtl/lot_evt_latch.sv
module lot_evt_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         grant_en,
  output logic [N-1:0] take,
  output logic [N-1:0] pend_q
);

  // Lowest index wins.
  always_comb begin
    take = '0;
    if (grant_en) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (pend_q[i]) take = N'(1) << i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~take) | evt;
  end

  // R7: a taken flag is cleared unless re-raised in the same cycle
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |=> ((pend_q & $past(take)) == ($past(evt) & $past(take))));

endmodule

// File: rtl/lot_dwell_timer.sv
module lot_dwell_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  // R2: the dwell counter steps down by one per cycle
  a_r2_dwell_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lot_count_reg.sv
module lot_count_reg
  import lot_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int CAPACITY = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             up,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blocked
);

  assign blocked = step_blocked(int'(cnt_q), CAPACITY, up);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= CNT_W'(CAPACITY);
    else if (apply) cnt_q <= CNT_W'(step_count(int'(cnt_q), CAPACITY, up));
  end

  // R5: the count never exceeds the capacity
  a_r5_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= CAPACITY);

  // R6: the count only moves when an operation is applied
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(cnt_q));

endmodule

// File: rtl/lot_space_ctrl.sv
module lot_space_ctrl
  import lot_pkg::*;
#(
  parameter int CAPACITY = 500,
  parameter int CNT_W    = 10,
  parameter int INC_CYC  = 5,
  parameter int DEC_CYC  = 5,
  parameter int RD_CYC   = 2,
  parameter int UPD_CYC  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             car_exit,
  input  logic             car_entry,
  input  logic             ticket_req,
  output logic             grant,
  output logic             lot_full,
  output logic             disp_stb,
  output logic [CNT_W-1:0] disp_count,
  output logic             sat_err
);

  localparam int DMAX_A = (INC_CYC > DEC_CYC) ? INC_CYC : DEC_CYC;
  localparam int DMAX_B = (RD_CYC > UPD_CYC) ? RD_CYC : UPD_CYC;
  localparam int DMAX   = (DMAX_A > DMAX_B) ? DMAX_A : DMAX_B;
  localparam int TW     = (DMAX > 1) ? $clog2(DMAX) : 1;

  lot_st_e          st_q, st_d;
  logic [SRC_N-1:0] evt, take, pend_q;
  logic             grant_en;
  logic             tmr_load, tmr_last;
  logic [TW-1:0]    tmr_val;
  logic             cnt_apply, cnt_up, cnt_blocked;
  logic [CNT_W-1:0] count;

  assign evt[SRC_EXIT]   = car_exit;
  assign evt[SRC_ENTRY]  = car_entry;
  assign evt[SRC_TICKET] = ticket_req;
  assign grant_en        = (st_q == ST_IDLE);

  lot_evt_latch #(.N(SRC_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt(evt), .grant_en(grant_en),
    .take(take), .pend_q(pend_q)
  );

  lot_dwell_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .last(tmr_last)
  );

  lot_count_reg #(.CNT_W(CNT_W), .CAPACITY(CAPACITY)) u_cnt (
    .clk(clk), .rst_n(rst_n), .apply(cnt_apply), .up(cnt_up),
    .cnt_q(count), .blocked(cnt_blocked)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (take[SRC_EXIT]) begin
          st_d = ST_INC;  tmr_load = 1'b1; tmr_val = TW'(INC_CYC - 1);
        end else if (take[SRC_ENTRY]) begin
          st_d = ST_DEC;  tmr_load = 1'b1; tmr_val = TW'(DEC_CYC - 1);
        end else if (take[SRC_TICKET]) begin
          st_d = ST_READ; tmr_load = 1'b1; tmr_val = TW'(RD_CYC - 1);
        end
      end
      ST_INC, ST_DEC: begin
        if (tmr_last) begin
          st_d = ST_UPD; tmr_load = 1'b1; tmr_val = TW'(UPD_CYC - 1);
        end
      end
      ST_READ: if (tmr_last) st_d = ST_IDLE;
      ST_UPD:  if (tmr_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cnt_apply  = (st_q == ST_INC || st_q == ST_DEC) && tmr_last;
  assign cnt_up     = (st_q == ST_INC);
  assign sat_err    = cnt_apply && cnt_blocked;
  assign grant      = (st_q == ST_READ) && tmr_last && (count != '0);
  assign lot_full   = (st_q == ST_READ) && tmr_last && (count == '0);
  assign disp_stb   = (st_q == ST_UPD) && tmr_last;
  assign disp_count = count;

  // R6: display strobe lasts one cycle
  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb |=> !disp_stb);

  // R4: an answer ends the read phase
  a_r4_answer_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || lot_full) |=> (st_q == ST_IDLE));

  // R5: a blocked step leaves the count as it was
  a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err |=> $stable(disp_count));

  // R8: idle with nothing pending stays idle
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pend_q == '0) |=> (st_q == ST_IDLE));

endmodule

// File: tb/lot_space_ctrl_test.sv
module lot_space_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CAP = 6;
  localparam int INC = 3;
  localparam int DEC = 4;
  localparam int RD  = 2;
  localparam int UPD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_exit = 1'b0, car_entry = 1'b0, ticket_req = 1'b0;
  logic grant, lot_full, disp_stb, sat_err;
  logic [9:0] disp_count;

  int vectors = 0;
  int errors = 0;
  int model;
  int stb_t[8], stb_v[8], n_stb, ans_t, ans_g, n_ans, err_t, n_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  lot_space_ctrl #(.CAPACITY(CAP), .CNT_W(10), .INC_CYC(INC),
                   .DEC_CYC(DEC), .RD_CYC(RD), .UPD_CYC(UPD)) uut (
    .clk(clk), .rst_n(rst_n), .car_exit(car_exit), .car_entry(car_entry),
    .ticket_req(ticket_req), .grant(grant), .lot_full(lot_full),
    .disp_stb(disp_stb), .disp_count(disp_count), .sat_err(sat_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Records output pulses for n cycles; k counts negedges after stimulus.
  task automatic rec(input int n);
    n_stb = 0; n_ans = 0; n_err = 0; ans_t = 0; ans_g = 0; err_t = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (disp_stb) begin
        if (n_stb < 8) begin stb_t[n_stb] = k; stb_v[n_stb] = int'(disp_count); end
        n_stb++;
      end
      if (grant || lot_full) begin
        n_ans++; ans_t = k; ans_g = int'(grant);
        if (grant && lot_full) n_ans++;
      end
      if (sat_err) begin n_err++; err_t = k; end
    end
  endtask

  // src: 0 exit, 1 entry, 2 ticket
  task automatic op(input int src);
    int dur, exp_cnt;
    bit exp_err;
    dur = (src == 0) ? INC : DEC;
    exp_err = (src == 0) ? (model >= CAP) : (src == 1 && model == 0);
    exp_cnt = (src == 2 || exp_err) ? model : ((src == 0) ? model + 1 : model - 1);
    fork
      begin
        if (src == 0) car_exit = 1'b1;
        else if (src == 1) car_entry = 1'b1;
        else ticket_req = 1'b1;
        @(negedge clk);
        car_exit = 1'b0; car_entry = 1'b0; ticket_req = 1'b0;
      end
      rec(30);
    join
    if (src == 2) begin
      chk(n_ans == 1, "R4 answer count", n_ans, 1);
      chk(ans_t == RD + 1, "R4 answer cycle", ans_t, RD + 1);
      chk(ans_g == int'(model > 0), "R4 grant vs full", ans_g, int'(model > 0));
      chk(n_stb == 0, "R4 no refresh", n_stb, 0);
    end else begin
      chk(n_stb == 1, "R6 one strobe", n_stb, 1);
      chk(stb_t[0] == dur + UPD + 1, (src == 0) ? "R2 strobe cycle" : "R3 strobe cycle",
          stb_t[0], dur + UPD + 1);
      chk(stb_v[0] == exp_cnt, "R6 strobe value", stb_v[0], exp_cnt);
      chk(n_err == int'(exp_err), "R5 error pulses", n_err, int'(exp_err));
      if (exp_err) chk(err_t == dur + 1, "R5 error cycle", err_t, dur + 1);
    end
    model = exp_cnt;
    chk(int'(disp_count) == model, (src == 0) ? "R2 count" : (src == 1) ? "R3 count" : "R4 count",
        int'(disp_count), model);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model = CAP;
    // R1 reset state
    chk(int'(disp_count) == CAP, "R1 reset count", int'(disp_count), CAP);
    chk(!grant && !lot_full && !disp_stb && !sat_err, "R1 outputs low",
        int'({grant, lot_full, disp_stb, sat_err}), 0);

    op(2);                                 // R4 grant when full of spaces
    op(0);                                 // R5 exit at capacity
    for (int i = 0; i < CAP; i++) op(1);   // R3 sweep down to zero
    op(1);                                 // R5 entry at zero
    op(2);                                 // R4 lot_full at zero
    for (int i = 0; i < 3; i++) op(0);     // R2 sweep up
    op(2);

    // R7/R8: all three sources plus a repeated entry while a decrement runs
    begin
      int c, s1, s2, s3;
      c = model;
      fork
        begin
          car_entry = 1'b1; @(negedge clk); car_entry = 1'b0;
          @(negedge clk);
          car_exit = 1'b1; car_entry = 1'b1; ticket_req = 1'b1;
          @(negedge clk);
          car_exit = 1'b0; car_entry = 1'b0; ticket_req = 1'b0;
          @(negedge clk);
          car_entry = 1'b1; @(negedge clk); car_entry = 1'b0;
        end
        rec(60);
      join
      s1 = DEC + UPD + 1;
      s2 = s1 + 1 + INC + UPD;
      s3 = s2 + 1 + DEC + UPD;
      chk(n_stb == 3, "R7 merged strobes", n_stb, 3);
      chk(stb_v[0] == c - 1 && stb_t[0] == s1, "R8 first op", stb_t[0], s1);
      chk(stb_v[1] == c && stb_t[1] == s2, "R8 exit served first", stb_v[1], c);
      chk(stb_v[2] == c - 1 && stb_t[2] == s3, "R8 entry served second", stb_v[2], c - 1);
      chk(n_ans == 1 && ans_t == s3 + 1 + RD, "R8 ticket served last", ans_t, s3 + 1 + RD);
      model = c - 1;
      chk(int'(disp_count) == model, "R7 final count", int'(disp_count), model);
    end

    // R7: pulse in the very cycle its flag is taken
    begin
      int c, s1;
      c = model;
      fork
        begin
          car_entry = 1'b1; @(negedge clk); @(negedge clk); car_entry = 1'b0;
        end
        rec(40);
      join
      s1 = DEC + UPD + 1;
      chk(n_stb == 2, "R7 back-to-back kept", n_stb, 2);
      chk(stb_t[0] == s1 && stb_v[0] == c - 1, "R7 first decrement", stb_v[0], c - 1);
      chk(stb_t[1] == s1 + 1 + DEC + UPD && stb_v[1] == c - 2, "R7 second decrement",
          stb_t[1], s1 + 1 + DEC + UPD);
      model = c - 2;
    end

    // R1: reset mid-run restores capacity
    car_exit = 1'b0;
    op(1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(int'(disp_count) == CAP, "R1 re-reset count", int'(disp_count), CAP);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule